// File: doc/BRIEF.md
# Converter Status and Request Logic

This block holds the status word of a three-pair sample rate converter and drives its service requests. Each pair (A, B, C) has an input FIFO and an output FIFO. The block compares the fill count of each FIFO with a programmable threshold. When an input FIFO is running low, the block asks for samples to be written. When an output FIFO holds enough data, it asks for samples to be read. From these conditions it raises one DMA request line per FIFO. It also forms a single interrupt request, which gathers every flag whose enable is set.

Two further conditions sit in the status word. The first is a sticky overload error, set by a pulse from the processing engine. The second is a debug flag that shows the filter engine is waiting. Software reads the eight-bit status word at any time. It clears the overload error with a write strobe to the status register; the written value plays no part. The FIFOs, the filter datapath, the DMA engine and the interrupt controller sit outside this block.

Top module: `src_status_req`

## Requirements
- R1: The status word layout is: bit 7 is the wait flag, bit 6 the overload error, bits 5/4/3 the output-ready flags of pairs C/B/A, and bits 2/1/0 the input-ready flags of pairs C/B/A. In each fill vector and threshold vector, pair A sits in the lowest CNT_W bits, then B, then C.
- R2: An output-ready flag is 1 exactly when that pair's output fill count is strictly greater than its output threshold. It is updated on the clock edge that samples the counts.
- R3: An input-ready flag is 1 exactly when that pair's input fill count is strictly less than its input threshold. It is updated on the clock edge that samples the counts.
- R4: Each DMA request output equals its fill-level flag, whatever the interrupt enables are set to.
- R5: A fill-level flag adds to the interrupt only while that pair's input or output interrupt enable is set. With every enable clear, the interrupt stays low.
- R6: An overload pulse sets the overload error, and the error stays set until it is cleared. It adds to the interrupt only while the overload interrupt enable is set.
- R7: A status write strobe clears the overload error, and its interrupt contribution, on the next edge. An overload pulse in the same cycle as the write leaves the error set.
- R8: The wait flag follows the wait input on each edge. It adds to the interrupt only while both the debug enable and the wait interrupt enable are set.
- R9: Status writes do not change the fill-level flags or the wait flag.
- R10: The interrupt output is registered. It changes on the same edge as the flags that cause it.
- R11: While reset is active, the status word, all DMA requests and the interrupt are 0. Reset asserts asynchronously. Release is synchronised over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_fill_i | input | 3*CNT_W | Input FIFO fill counts, pair A lowest |
| in_thr_i | input | 3*CNT_W | Input thresholds, pair A lowest |
| out_fill_i | input | 3*CNT_W | Output FIFO fill counts, pair A lowest |
| out_thr_i | input | 3*CNT_W | Output thresholds, pair A lowest |
| ovl_evt_i | input | 1 | Overload event pulse |
| fp_wait_i | input | 1 | Filter engine waiting |
| in_irq_en_i | input | 3 | Input-ready interrupt enables, bit 0 = pair A |
| out_irq_en_i | input | 3 | Output-ready interrupt enables, bit 0 = pair A |
| ovl_irq_en_i | input | 1 | Overload interrupt enable |
| dbg_en_i | input | 1 | Debug mode enable |
| wait_irq_en_i | input | 1 | Wait interrupt enable |
| stat_wr_i | input | 1 | Write strobe to the status register |
| stat_rdata_o | output | 8 | Status word |
| dma_in_req_o | output | 3 | Input DMA requests, bit 0 = pair A |
| dma_out_req_o | output | 3 | Output DMA requests, bit 0 = pair A |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every result of this block is due on the first rising edge after its stimulus is applied. This covers the flags, the status word, the DMA lines, overload set and clear, and the interrupt. The exception is reset release, which needs two further edges before the flags start to follow their inputs. The bench changes inputs in mid-cycle and reads outputs 2 ns after the next rising edge. It compares them there against a model that updates on the same edge. Directed checks then probe threshold equality, a write that coincides with an overload pulse, and the two-enable gate on the wait flag, each one edge after its stimulus.

// File: rtl/src_status_pkg.sv
package src_status_pkg;

  localparam int PAIRS    = 3;
  localparam int STAT_W   = 8;
  localparam int BIT_WAIT = 7;
  localparam int BIT_OVL  = 6;
  localparam int OUT_LSB  = 3;
  localparam int IN_LSB   = 0;

  typedef logic [PAIRS-1:0]  pair_vec_t;
  typedef logic [STAT_W-1:0] stat_word_t;

  typedef struct packed {
    pair_vec_t in_en;
    pair_vec_t out_en;
    logic      ovl_en;
    logic      dbg_en;
    logic      wait_en;
  } irq_cfg_t;

  function automatic stat_word_t pack_status(
    input logic      wait_f,
    input logic      ovl_f,
    input pair_vec_t out_f,
    input pair_vec_t in_f
  );
    stat_word_t w;
    w = '0;
    w[BIT_WAIT] = wait_f;
    w[BIT_OVL]  = ovl_f;
    w[OUT_LSB +: PAIRS] = out_f;
    w[IN_LSB  +: PAIRS] = in_f;
    return w;
  endfunction

endpackage

// File: rtl/src_status_rst_sync.sv
module src_status_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/src_status_level_flag.sv
module src_status_level_flag #(
  parameter int CNT_W = 6,
  parameter bit ABOVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             flag_d_o,
  output logic             flag_q_o
);

  logic flag_d;
  logic flag_q;

  generate
    if (ABOVE) begin : g_above
      always_comb flag_d = (fill_i > thr_i);
    end else begin : g_below
      always_comb flag_d = (fill_i < thr_i);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_d_o = flag_d;
  assign flag_q_o = flag_q;

endmodule

// File: rtl/src_status_ovl_err.sv
module src_status_ovl_err (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic err_d_o,
  output logic err_q_o
);

  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_en = evt_i | clr_i;
    err_d  = err_q;
    if (clr_i) err_d = 1'b0;
    if (evt_i) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err_d_o = err_d;
  assign err_q_o = err_q;

endmodule

// File: rtl/src_status_irq_merge.sv
module src_status_irq_merge
  import src_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pair_vec_t in_d_i,
  input  pair_vec_t out_d_i,
  input  logic      ovl_d_i,
  input  logic      wait_d_i,
  input  irq_cfg_t  cfg_i,
  output logic      irq_o
);

  logic      irq_d;
  logic      irq_q;
  pair_vec_t in_hit;
  pair_vec_t out_hit;
  logic      dbg_hit;

  always_comb begin
    in_hit  = in_d_i  & cfg_i.in_en;
    out_hit = out_d_i & cfg_i.out_en;
    dbg_hit = wait_d_i & cfg_i.dbg_en & cfg_i.wait_en;
    irq_d   = (|in_hit) | (|out_hit) | (ovl_d_i & cfg_i.ovl_en) | dbg_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/src_status_req.sv
module src_status_req
  import src_status_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAIRS*CNT_W-1:0] in_fill_i,
  input  logic [PAIRS*CNT_W-1:0] in_thr_i,
  input  logic [PAIRS*CNT_W-1:0] out_fill_i,
  input  logic [PAIRS*CNT_W-1:0] out_thr_i,
  input  logic                   ovl_evt_i,
  input  logic                   fp_wait_i,
  input  logic [PAIRS-1:0]       in_irq_en_i,
  input  logic [PAIRS-1:0]       out_irq_en_i,
  input  logic                   ovl_irq_en_i,
  input  logic                   dbg_en_i,
  input  logic                   wait_irq_en_i,
  input  logic                   stat_wr_i,
  output logic [STAT_W-1:0]      stat_rdata_o,
  output logic [PAIRS-1:0]       dma_in_req_o,
  output logic [PAIRS-1:0]       dma_out_req_o,
  output logic                   irq_o
);

  logic      rst_int_n;
  pair_vec_t in_d, in_q;
  pair_vec_t out_d, out_q;
  logic      ovl_d, ovl_q;
  logic      wait_d, wait_q;
  irq_cfg_t  cfg;

  src_status_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    src_status_level_flag #(.CNT_W(CNT_W), .ABOVE(1'b0)) u_in_flag (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .fill_i   (in_fill_i[p*CNT_W +: CNT_W]),
      .thr_i    (in_thr_i[p*CNT_W +: CNT_W]),
      .flag_d_o (in_d[p]),
      .flag_q_o (in_q[p])
    );
    src_status_level_flag #(.CNT_W(CNT_W), .ABOVE(1'b1)) u_out_flag (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .fill_i   (out_fill_i[p*CNT_W +: CNT_W]),
      .thr_i    (out_thr_i[p*CNT_W +: CNT_W]),
      .flag_d_o (out_d[p]),
      .flag_q_o (out_q[p])
    );
  end

  src_status_ovl_err u_ovl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt_i   (ovl_evt_i),
    .clr_i   (stat_wr_i),
    .err_d_o (ovl_d),
    .err_q_o (ovl_q)
  );

  always_comb wait_d = fp_wait_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wait_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
    end
  end

  always_comb begin
    cfg.in_en   = in_irq_en_i;
    cfg.out_en  = out_irq_en_i;
    cfg.ovl_en  = ovl_irq_en_i;
    cfg.dbg_en  = dbg_en_i;
    cfg.wait_en = wait_irq_en_i;
  end

  src_status_irq_merge u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_d_i   (in_d),
    .out_d_i  (out_d),
    .ovl_d_i  (ovl_d),
    .wait_d_i (wait_d),
    .cfg_i    (cfg),
    .irq_o    (irq_o)
  );

  assign stat_rdata_o  = pack_status(wait_q, ovl_q, out_q, in_q);
  assign dma_in_req_o  = in_q;
  assign dma_out_req_o = out_q;

endmodule

// File: rtl/src_status_req_chk.sv
module src_status_req_chk
  import src_status_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic                   clk,
  input logic                   rst_int_n,
  input logic [PAIRS*CNT_W-1:0] in_fill_i,
  input logic [PAIRS*CNT_W-1:0] in_thr_i,
  input logic [PAIRS*CNT_W-1:0] out_fill_i,
  input logic [PAIRS*CNT_W-1:0] out_thr_i,
  input logic                   ovl_evt_i,
  input logic [PAIRS-1:0]       in_irq_en_i,
  input logic [PAIRS-1:0]       out_irq_en_i,
  input logic                   ovl_irq_en_i,
  input logic                   dbg_en_i,
  input logic                   wait_irq_en_i,
  input logic                   stat_wr_i,
  input logic [STAT_W-1:0]      stat_rdata_o,
  input logic [PAIRS-1:0]       dma_in_req_o,
  input logic [PAIRS-1:0]       dma_out_req_o,
  input logic                   irq_o
);

  logic past_ok;
  logic none_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) past_ok <= 1'b0;
    else            past_ok <= 1'b1;
  end

  assign none_en = (in_irq_en_i == '0) && (out_irq_en_i == '0) && !ovl_irq_en_i
                   && !(dbg_en_i && wait_irq_en_i);

  for (genvar p = 0; p < PAIRS; p++) begin : g_chk
    assert_out_flag_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
      past_ok |-> stat_rdata_o[OUT_LSB+p] ==
        ($past(out_fill_i[p*CNT_W +: CNT_W]) > $past(out_thr_i[p*CNT_W +: CNT_W])));
    assert_in_flag_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
      past_ok |-> stat_rdata_o[IN_LSB+p] ==
        ($past(in_fill_i[p*CNT_W +: CNT_W]) < $past(in_thr_i[p*CNT_W +: CNT_W])));
    assert_dma_out_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
      past_ok |-> dma_out_req_o[p] ==
        ($past(out_fill_i[p*CNT_W +: CNT_W]) > $past(out_thr_i[p*CNT_W +: CNT_W])));
    assert_dma_in_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
      past_ok |-> dma_in_req_o[p] ==
        ($past(in_fill_i[p*CNT_W +: CNT_W]) < $past(in_thr_i[p*CNT_W +: CNT_W])));
  end

  assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    past_ok && $past(none_en) |-> !irq_o);

  assert_ovl_set_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovl_evt_i |=> stat_rdata_o[BIT_OVL]);

  assert_ovl_hold_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_rdata_o[BIT_OVL] && !stat_wr_i |=> stat_rdata_o[BIT_OVL]);

  assert_ovl_clear_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_wr_i && !ovl_evt_i |=> !stat_rdata_o[BIT_OVL]);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_int_n |-> (stat_rdata_o == '0) && (dma_in_req_o == '0)
                   && (dma_out_req_o == '0) && !irq_o);

endmodule

bind src_status_req src_status_req_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .in_fill_i     (in_fill_i),
  .in_thr_i      (in_thr_i),
  .out_fill_i    (out_fill_i),
  .out_thr_i     (out_thr_i),
  .ovl_evt_i     (ovl_evt_i),
  .in_irq_en_i   (in_irq_en_i),
  .out_irq_en_i  (out_irq_en_i),
  .ovl_irq_en_i  (ovl_irq_en_i),
  .dbg_en_i      (dbg_en_i),
  .wait_irq_en_i (wait_irq_en_i),
  .stat_wr_i     (stat_wr_i),
  .stat_rdata_o  (stat_rdata_o),
  .dma_in_req_o  (dma_in_req_o),
  .dma_out_req_o (dma_out_req_o),
  .irq_o         (irq_o)
);

// File: tb/tb_src_status_req.sv
`timescale 1ns/1ps
module tb_src_status_req;

  localparam int CW = 6;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*CW-1:0] in_fill = '0, in_thr = '0, out_fill = '0, out_thr = '0;
  logic ovl_evt = 1'b0, fp_wait = 1'b0;
  logic [NP-1:0] in_en = '0, out_en = '0;
  logic ovl_en = 1'b0, dbg_en = 1'b0, wait_en = 1'b0, stat_wr = 1'b0;
  logic [7:0] stat;
  logic [NP-1:0] dma_in, dma_out;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  src_status_req #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_fill_i(in_fill), .in_thr_i(in_thr),
    .out_fill_i(out_fill), .out_thr_i(out_thr),
    .ovl_evt_i(ovl_evt), .fp_wait_i(fp_wait),
    .in_irq_en_i(in_en), .out_irq_en_i(out_en),
    .ovl_irq_en_i(ovl_en), .dbg_en_i(dbg_en), .wait_irq_en_i(wait_en),
    .stat_wr_i(stat_wr),
    .stat_rdata_o(stat), .dma_in_req_o(dma_in), .dma_out_req_o(dma_out),
    .irq_o(irq)
  );

  // behavioural reference model
  bit m_in[NP], m_out[NP];
  bit m_ovl, m_wait, m_irq;
  int since_rel;

  always @(posedge clk or negedge rst_n) begin
    bit n_in[NP], n_out[NP];
    bit n_ovl, n_irq;
    if (!rst_n) begin
      since_rel = 0;
      m_ovl <= 0; m_wait <= 0; m_irq <= 0;
      for (int p = 0; p < NP; p++) begin m_in[p] <= 0; m_out[p] <= 0; end
    end else if (since_rel < 2) begin
      since_rel = since_rel + 1;
    end else begin
      n_irq = 0;
      for (int p = 0; p < NP; p++) begin
        n_in[p]  = int'(in_fill[p*CW +: CW]) < int'(in_thr[p*CW +: CW]);
        n_out[p] = int'(out_fill[p*CW +: CW]) > int'(out_thr[p*CW +: CW]);
        if (n_in[p] && in_en[p])   n_irq = 1;
        if (n_out[p] && out_en[p]) n_irq = 1;
        m_in[p] <= n_in[p];
        m_out[p] <= n_out[p];
      end
      n_ovl = ovl_evt ? 1'b1 : (stat_wr ? 1'b0 : m_ovl);
      if (n_ovl && ovl_en) n_irq = 1;
      if (fp_wait && dbg_en && wait_en) n_irq = 1;
      m_ovl <= n_ovl;
      m_wait <= fp_wait;
      m_irq <= n_irq;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int ein, eout;
    ein = 0; eout = 0;
    for (int p = 0; p < NP; p++) begin
      ein  |= int'(m_in[p])  << p;
      eout |= int'(m_out[p]) << p;
    end
    chk("R1 R8 wait bit", stat[7], m_wait);
    chk("R6 R7 overload bit", stat[6], m_ovl);
    chk("R2 output flags", stat[5:3], eout);
    chk("R3 input flags", stat[2:0], ein);
    chk("R4 dma lines", {dma_out, dma_in}, (eout << 3) | ein);
    chk("R10 interrupt", irq, m_irq);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    compare_model();
  endtask

  task automatic level_all(input int v);
    for (int p = 0; p < NP; p++) begin
      in_fill[p*CW +: CW] = CW'(v); in_thr[p*CW +: CW] = CW'(v);
      out_fill[p*CW +: CW] = CW'(v); out_thr[p*CW +: CW] = CW'(v);
    end
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) tick();
    chk("R11 reset status", stat, 0);
    chk("R11 reset irq", irq, 0);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // randomised traffic
    for (int i = 0; i < 600; i++) begin
      in_fill = NP*CW'($urandom); in_thr = NP*CW'($urandom);
      out_fill = NP*CW'($urandom); out_thr = NP*CW'($urandom);
      ovl_evt = ($urandom_range(0, 15) == 0);
      stat_wr = ($urandom_range(0, 7) == 0);
      fp_wait = $urandom_range(0, 1);
      in_en = NP'($urandom); out_en = NP'($urandom);
      ovl_en = $urandom_range(0, 1); dbg_en = $urandom_range(0, 1);
      wait_en = $urandom_range(0, 1);
      tick();
    end

    // quiet, clear overload
    in_en = '0; out_en = '0; ovl_en = 0; dbg_en = 0; wait_en = 0;
    ovl_evt = 0; fp_wait = 0; stat_wr = 1; level_all(20);
    tick();
    stat_wr = 0;
    tick();
    chk("R2 R3 equality gives no flags", stat, 0);

    // R1 layout
    out_fill[2*CW +: CW] = 6'd21;
    in_fill[1*CW +: CW] = 6'd19;
    tick();
    chk("R1 status layout", stat, 8'h22);
    level_all(20);

    // boundaries pair A
    in_fill[0 +: CW] = 6'd9; out_fill[0 +: CW] = 6'd21;
    tick();
    chk("R3 below threshold", stat[0], 1);
    chk("R2 above threshold", stat[3], 1);
    chk("R4 dma with enables clear", {dma_out[0], dma_in[0]}, 2'b11);
    chk("R5 no irq without enable", irq, 0);
    in_en = 3'b001;
    tick();
    chk("R5 irq with input enable", irq, 1);
    in_en = 3'b000; out_en = 3'b001;
    tick();
    chk("R5 irq with output enable", irq, 1);
    out_en = 3'b000;
    stat_wr = 1;
    tick();
    chk("R9 write keeps fill flags", stat[3] & stat[0], 1);
    stat_wr = 0; level_all(20);
    tick();

    // overload
    ovl_en = 1; ovl_evt = 1;
    tick();
    chk("R6 overload set", stat[6], 1);
    chk("R6 overload irq", irq, 1);
    ovl_evt = 0;
    tick();
    chk("R6 overload sticky", stat[6], 1);
    stat_wr = 1; ovl_evt = 1;
    tick();
    chk("R7 pulse beats write", stat[6], 1);
    ovl_evt = 0;
    tick();
    chk("R7 write clears overload", stat[6], 0);
    chk("R7 irq drops with overload", irq, 0);
    stat_wr = 0; ovl_en = 0;

    // wait gating
    fp_wait = 1; dbg_en = 1;
    tick();
    chk("R8 wait flag", stat[7], 1);
    chk("R8 one enable gives no irq", irq, 0);
    wait_en = 1;
    tick();
    chk("R8 both enables irq", irq, 1);
    stat_wr = 1;
    tick();
    chk("R9 write keeps wait flag", stat[7], 1);
    stat_wr = 0; dbg_en = 0;
    tick();
    chk("R8 debug off no irq", irq, 0);

    // mid-run reset
    in_fill[0 +: CW] = 6'd1;
    tick();
    #1 rst_n = 1'b0;
    #2;
    chk("R11 async reset status", stat, 0);
    chk("R11 async reset dma", {dma_out, dma_in}, 0);
    chk("R11 async reset irq", irq, 0);
    tick();
    #1 rst_n = 1'b1;
    repeat (4) tick();
    chk("R11 flags resume after release", stat[0], 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule